// File: doc/BRIEF.md
# Bus Clock Ratio Divider

This block runs on the fast core clock and produces two single-cycle clock-enable strobes: one for a high-speed system bus and one for a low-speed peripheral bus. Both strobes are phase-aligned to the core clock. Logic in either bus domain advances only on core-clock edges where its enable is high.

A small control word sets the ratios. It is loaded through a one-cycle write port. An encoded two-bit field picks the system-bus divisor, and a separate camera override input can stretch that divisor. One further bit picks whether the peripheral bus runs at the system-bus rate or at half of it. Because the peripheral ratio is taken relative to the system bus, every peripheral strobe falls on a system-bus strobe.

Any divisor other than one raises a request asking the core to switch to asynchronous bus mode. A new ratio is adopted only at a cycle that starts a full period of both the old and the new sequence, so no bus period is ever cut short.

Top module: `bus_ratio_div`

## Requirements
- R1: After reset the stored control word is 0, both enables are high on every core cycle, and `async_req` is 0.
- R2: With `cam_ovr`=0, control bits [2:1] set the system-bus divisor: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 3. `hbus_en` is high once per divisor core cycles.
- R3: With `cam_ovr`=1, field 2'b10 gives divisor 8 and 2'b11 gives divisor 6. Fields 2'b00 and 2'b01 still give 1 and 2.
- R4: When control bit 0 is 1, `pbus_en` is high on every second `hbus_en` pulse. When bit 0 is 0, `pbus_en` equals `hbus_en`. `pbus_en` is never high without `hbus_en`.
- R5: Control word 0x5 with `cam_ovr`=0 gives core : system : peripheral ratios of 8 : 2 : 1. That means `hbus_en` is high every 4th cycle and `pbus_en` every 8th cycle.
- R6: `async_req` is 1 exactly when the stored bits [2:1] are non-zero, whatever `cam_ovr` is. It follows a write in the first cycle after the capturing edge and changes at no other time.
- R7: Control bit 3 and any higher bits have no effect on either enable.
- R8: After a write, the old sequence continues until the next cycle in which its `pbus_en` is high. That cycle has both enables high and is cycle 0 of the new sequence, and the new periods are counted from it.
- R9: A change of `cam_ovr` is adopted under the same rule as a write: the old sequence finishes its running peripheral period first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | CTRL_W | Control word: bit 0 peripheral half-rate, bits [2:1] system divisor field, upper bits ignored |
| cam_ovr | input | 1 | Camera override that stretches the quarter-rate and third-rate settings |
| hbus_en | output | 1 | System-bus clock enable strobe |
| pbus_en | output | 1 | Peripheral-bus clock enable strobe |
| async_req | output | 1 | Request for the core to use asynchronous bus mode |

## Verification
A ratio change and an enable boundary can fall in the same cycle. A write or an override flip is presented while the old sequence is mid-period or exactly on a peripheral strobe. The bench pins each write to a known offset from an observed `pbus_en` pulse, and predicts cycle by cycle whether the old pattern continues or the new one starts. It then compares both strobes against that prediction for every offset through the switch. The fast-to-slow and slow-to-fast directions are both provoked, and so is an override change, so that the adoption cycle is judged from both sides.

// File: rtl/bus_ratio_pkg.sv
package bus_ratio_pkg;

    // width of the system-bus count (divisor - 1, largest divisor 8)
    localparam int HCNT_W = 3;

    // bit positions inside the control word
    localparam int PHALF_BIT = 0;
    localparam int HFLD_LO   = 1;
    localparam int HFLD_HI   = 2;

    typedef enum logic [1:0] {
        HSEL_DIV1  = 2'b00,
        HSEL_DIV2  = 2'b01,
        HSEL_QUART = 2'b10,
        HSEL_THIRD = 2'b11
    } hsel_e;

    typedef struct packed {
        logic [HCNT_W-1:0] h_m1;   // system divisor minus one
        logic              p_m1;   // peripheral divisor (relative) minus one
    } ratio_cfg_t;

    function automatic ratio_cfg_t decode_ratio(input hsel_e fld, input logic ovr,
                                                input logic phalf);
        ratio_cfg_t c;
        c.p_m1 = phalf;
        unique case (fld)
            HSEL_DIV1:  c.h_m1 = HCNT_W'(0);
            HSEL_DIV2:  c.h_m1 = HCNT_W'(1);
            HSEL_QUART: c.h_m1 = ovr ? HCNT_W'(7) : HCNT_W'(3);
            HSEL_THIRD: c.h_m1 = ovr ? HCNT_W'(5) : HCNT_W'(2);
            default:    c.h_m1 = HCNT_W'(0);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bus_ratio_regs.sv
module bus_ratio_regs
    import bus_ratio_pkg::*;
#(
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output hsel_e             fld,
    output logic              phalf,
    output logic              async_req
);
    localparam int KEEP_W = HFLD_HI + 1;

    logic [KEEP_W-1:0] ctrl_q;
    logic              unused_hi;

    assign unused_hi = ^wdata[CTRL_W-1:KEEP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= wdata[KEEP_W-1:0];
        end
    end

    assign fld       = hsel_e'(ctrl_q[HFLD_HI:HFLD_LO]);
    assign phalf     = ctrl_q[PHALF_BIT];
    assign async_req = (fld != HSEL_DIV1);

    // R6
    async_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(we) |-> $stable(async_req));

endmodule

// File: rtl/bus_ratio_switch.sv
module bus_ratio_switch
    import bus_ratio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hsel_e      fld,
    input  logic       phalf,
    input  logic       ovr,
    input  logic       boundary,
    output ratio_cfg_t cfg_next,
    output ratio_cfg_t cfg_q
);
    ratio_cfg_t want;
    logic       adopt;

    always_comb begin
        want     = decode_ratio(fld, ovr, phalf);
        adopt    = boundary && (want != cfg_q);
        cfg_next = adopt ? want : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_next;
        end
    end

    // R8 / R9
    cfg_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q != $past(cfg_q)) |-> $past(boundary));

endmodule

// File: rtl/bus_ratio_count.sv
module bus_ratio_count
    import bus_ratio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ratio_cfg_t cfg_next,
    input  ratio_cfg_t cfg_q,
    output logic       hbus_en,
    output logic       pbus_en,
    output logic       boundary
);
    logic [HCNT_W-1:0] hcnt;
    logic              pcnt;
    logic              hwrap;

    assign hbus_en  = (hcnt == '0);
    assign pbus_en  = hbus_en && !pcnt;
    assign boundary = pbus_en;

    // counting uses the configuration that holds for the next cycle's index
    assign hwrap = (hcnt == cfg_next.h_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            pcnt <= 1'b0;
        end else begin
            hcnt <= hwrap ? '0 : hcnt + HCNT_W'(1);
            if (hwrap) begin
                pcnt <= (pcnt == cfg_next.p_m1) ? 1'b0 : 1'b1;
            end
        end
    end

    // R2 / R3
    hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        hcnt <= cfg_q.h_m1);

    // R4
    pcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt |-> cfg_q.p_m1);

endmodule

// File: rtl/bus_ratio_div.sv
module bus_ratio_div
    import bus_ratio_pkg::*;
#(
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cam_ovr,
    output logic              hbus_en,
    output logic              pbus_en,
    output logic              async_req
);
    hsel_e      fld;
    logic       phalf;
    logic       boundary;
    ratio_cfg_t cfg_next;
    ratio_cfg_t cfg_q;

    bus_ratio_regs #(.CTRL_W(CTRL_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .we        (ctrl_we),
        .wdata     (ctrl_wdata),
        .fld       (fld),
        .phalf     (phalf),
        .async_req (async_req)
    );

    bus_ratio_switch switch_i (
        .clk      (clk),
        .rst      (rst),
        .fld      (fld),
        .phalf    (phalf),
        .ovr      (cam_ovr),
        .boundary (boundary),
        .cfg_next (cfg_next),
        .cfg_q    (cfg_q)
    );

    bus_ratio_count count_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_next (cfg_next),
        .cfg_q    (cfg_q),
        .hbus_en  (hbus_en),
        .pbus_en  (pbus_en),
        .boundary (boundary)
    );

    // R4
    p_on_h_chk: assert property (@(posedge clk) disable iff (rst)
        pbus_en |-> hbus_en);

    // R1
    reset_full_rate_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> hbus_en && pbus_en && !async_req);

endmodule

// File: tb/bus_ratio_div_tb_top.sv
module bus_ratio_div_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic       cam_ovr = 1'b0;
    logic       hbus_en, pbus_en, async_req;
    int         checks = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    bus_ratio_div #(.CTRL_W(4)) dut_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cam_ovr(cam_ovr), .hbus_en(hbus_en), .pbus_en(pbus_en),
        .async_req(async_req)
    );

    task automatic report(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [3:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic sync_pulse();
        for (int k = 0; k < 80; k++) begin
            if (pbus_en) break;
            @(negedge clk);
        end
    endtask

    // steady-state pattern: hbus every h cycles, pbus every h*p cycles
    task automatic check_pattern(input int h, input int p, input string tag);
        int bad = 0;
        int act = 0;
        int exp = 0;
        repeat (40) @(negedge clk);
        sync_pulse();
        for (int i = 0; i < 4 * h * p; i++) begin
            int eh = (i % h == 0) ? 1 : 0;
            int ep = (i % (h * p) == 0) ? 1 : 0;
            if (bad == 0 && (int'(hbus_en) != eh || int'(pbus_en) != ep)) begin
                bad = 1;
                act = 2 * int'(hbus_en) + int'(pbus_en);
                exp = 2 * eh + ep;
            end
            @(negedge clk);
        end
        report(tag, $sformatf("pattern h=%0d p=%0d (enc 2*h+p)", h, p), act, exp);
    endtask

    task automatic t_reset();
        int ok = 1;
        @(negedge clk);
        report("R1", "async_req in reset state", int'(async_req), 0);
        for (int i = 0; i < 6; i++) begin
            if (!hbus_en || !pbus_en) ok = 0;
            @(negedge clk);
        end
        report("R1", "both enables every cycle after reset", ok, 1);
    endtask

    task automatic t_decode();
        cam_ovr = 1'b0;
        write_ctrl(4'h2); check_pattern(2, 1, "R2");
        write_ctrl(4'h4); check_pattern(4, 1, "R2");
        write_ctrl(4'h6); check_pattern(3, 1, "R2");
        write_ctrl(4'h0); check_pattern(1, 1, "R2");
    endtask

    task automatic t_override();
        cam_ovr = 1'b1;
        write_ctrl(4'h4); check_pattern(8, 1, "R3");
        write_ctrl(4'h6); check_pattern(6, 1, "R3");
        write_ctrl(4'h2); check_pattern(2, 1, "R3");
        write_ctrl(4'h0); check_pattern(1, 1, "R3");
        cam_ovr = 1'b0;
    endtask

    task automatic t_periph();
        write_ctrl(4'h7); check_pattern(3, 2, "R4");
        write_ctrl(4'h3); check_pattern(2, 2, "R4");
        write_ctrl(4'h1); check_pattern(1, 2, "R4");
        write_ctrl(4'h5); check_pattern(4, 2, "R5");
    endtask

    task automatic t_async();
        write_ctrl(4'h0);
        report("R6", "async_req for field 00", int'(async_req), 0);
        write_ctrl(4'h2);
        report("R6", "async_req for field 01", int'(async_req), 1);
        cam_ovr = 1'b1;
        @(negedge clk);
        report("R6", "async_req unchanged by override", int'(async_req), 1);
        write_ctrl(4'h1);
        report("R6", "async_req field 00 with override", int'(async_req), 0);
        cam_ovr = 1'b0;
        write_ctrl(4'h6);
        report("R6", "async_req for field 11", int'(async_req), 1);
    endtask

    task automatic t_bit3();
        write_ctrl(4'hD); check_pattern(4, 2, "R7");
        write_ctrl(4'h8); check_pattern(1, 1, "R7");
    endtask

    task automatic t_switch();
        int bad = 0;
        int act = 0;
        int exp = 0;
        // slow to fast: 0x5 -> 0x0, written at the cycle of a pulse
        write_ctrl(4'h5);
        repeat (40) @(negedge clk);
        sync_pulse();
        ctrl_we = 1'b1; ctrl_wdata = 4'h0;
        @(negedge clk);
        ctrl_we = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            int eh = (i >= 8) ? 1 : ((i == 4) ? 1 : 0);
            int ep = (i >= 8) ? 1 : 0;
            if (bad == 0 && (int'(hbus_en) != eh || int'(pbus_en) != ep)) begin
                bad = 1; act = 2 * int'(hbus_en) + int'(pbus_en); exp = 2 * eh + ep;
            end
            @(negedge clk);
        end
        report("R8", "slow-to-fast switch (enc 2*h+p)", act, exp);
        // fast to slow: 0x0 -> 0x5
        bad = 0; act = 0; exp = 0;
        repeat (4) @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = 4'h5;
        @(negedge clk);
        ctrl_we = 1'b0;
        for (int i = 1; i <= 17; i++) begin
            int j = i - 1;
            int eh = (j % 4 == 0) ? 1 : 0;
            int ep = (j % 8 == 0) ? 1 : 0;
            if (bad == 0 && (int'(hbus_en) != eh || int'(pbus_en) != ep)) begin
                bad = 1; act = 2 * int'(hbus_en) + int'(pbus_en); exp = 2 * eh + ep;
            end
            @(negedge clk);
        end
        report("R8", "fast-to-slow switch (enc 2*h+p)", act, exp);
    endtask

    task automatic t_ovr_switch();
        int bad = 0;
        int act = 0;
        int exp = 0;
        cam_ovr = 1'b0;
        write_ctrl(4'h4);
        repeat (40) @(negedge clk);
        sync_pulse();
        @(negedge clk);
        cam_ovr = 1'b1;                 // offset 1, mid-period
        for (int i = 1; i <= 21; i++) begin
            int eh = (i >= 4 && ((i - 4) % 8 == 0)) ? 1 : 0;
            int ep = eh;
            if (bad == 0 && (int'(hbus_en) != eh || int'(pbus_en) != ep)) begin
                bad = 1; act = 2 * int'(hbus_en) + int'(pbus_en); exp = 2 * eh + ep;
            end
            @(negedge clk);
        end
        report("R9", "override adopted at period end (enc 2*h+p)", act, exp);
        cam_ovr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_override();
        t_periph();
        t_async();
        t_bit3();
        t_switch();
        t_ovr_switch();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule